// File: doc/BRIEF.md
# Prescaled 64-bit Machine Timer

This block is a memory-mapped timer for a single hart. It holds one 64-bit up-counter and one 64-bit compare value. While counting is enabled, a prescaler divides the clock by a programmable amount, and on every resulting tick the counter grows by a programmable step. A level interrupt is raised whenever counting is on, the interrupt is enabled, and the counter has reached or passed the compare value. Software reaches the block through a plain 32-bit register port. The port has a write strobe, a byte address, write data, and combinational read data.

Software programs the block as follows. It writes the compare halves, sets the step and prescale, enables the interrupt, and then turns counting on. Two test hooks are provided. One forces the interrupt line high until software touches the timer again. The other emits a one-cycle pulse on the fatal alert output.

Top module: `mtimer_top`

## Requirements
- R1: Offset 0x004 bit 0 is the count enable. While it is 0, the counter holds its value. The register reads back as {31'b0, enable}.
- R2: Offset 0x10C holds the prescale in bits 11:0 and the step in bits 23:16. It resets to 0x00010000 (prescale 0, step 1). All other bits read as 0.
- R3: While enabled, a tick occurs once every prescale+1 clocks, and each tick adds the step to the counter. The divider restarts from zero when counting is off or when 0x10C is written. No tick occurs in the cycle of that write.
- R4: Offset 0x110 and offset 0x114 hold the low and high 32 bits of the counter. A write replaces only that half. A write takes precedence over a tick in the same cycle. The carry from the low half propagates into the high half.
- R5: Offset 0x118 and offset 0x11C hold the low and high halves of the compare value. Each half resets to 0xFFFFFFFF. A write replaces only its own half.
- R6: The interrupt is asserted when all three conditions hold: enable is 1, the interrupt enable is 1, and the unsigned 64-bit counter is >= compare.
- R7: Offset 0x104 bit 0 reads the present interrupt level. Writes to 0x104 have no effect.
- R8: Writing a 1 to bit 0 of offset 0x108 sets a sticky flag that drives the interrupt high from the next cycle, whatever the enables are. A write to 0x004, 0x100, 0x110, 0x114, 0x118 or 0x11C clears the flag.
- R9: Writing a 1 to bit 0 of offset 0x000 makes the alert output high for exactly the following cycle. Writing a 0 there produces no pulse.
- R10: After reset the counter is 0, the count enable and interrupt enable are 0, and both the interrupt and the alert are low.
- R11: Offsets 0x000 and 0x108 read as 0. Every unmapped or misaligned address reads 0, and a write to such an address changes nothing.
- R12: Offset 0x100 bit 0 is the interrupt enable. It reads back as {31'b0, ie}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 9 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Level timer interrupt |
| alert_o | output | 1 | One-cycle fatal alert pulse |

## Verification
The bench uses the default parameters: a 64-bit counter, a 12-bit prescale and an 8-bit step. A low counter half loaded near 0xFFFFFFFF, combined with step 16, carries into the high half within a few cycles. This makes the 64-bit carry and the high-half compare reachable without long runs. Prescale values of 0 and 3 exercise both the per-clock tick and the divided tick. A configuration write in the middle of a run shows the divider restarting.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  localparam int REG_AW = 9;
  localparam logic [REG_AW-1:0] OFS_ALERT = 9'h000;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 9'h004;
  localparam logic [REG_AW-1:0] OFS_IE    = 9'h100;
  localparam logic [REG_AW-1:0] OFS_STAT  = 9'h104;
  localparam logic [REG_AW-1:0] OFS_TEST  = 9'h108;
  localparam logic [REG_AW-1:0] OFS_CFG   = 9'h10C;
  localparam logic [REG_AW-1:0] OFS_VLO   = 9'h110;
  localparam logic [REG_AW-1:0] OFS_VHI   = 9'h114;
  localparam logic [REG_AW-1:0] OFS_CLO   = 9'h118;
  localparam logic [REG_AW-1:0] OFS_CHI   = 9'h11C;
  localparam int STEP_LSB = 16;
endpackage

// File: rtl/mtimer_prescale.sv
module mtimer_prescale #(
  parameter int PW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          restart_i,
  input  logic [PW-1:0] limit_i,
  output logic          tick_o
);
  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = run_i && !restart_i && (cnt_q == limit_i);
    if (!run_i || restart_i || tick_o) cnt_d = '0;
    else                               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R3
  presc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit_i);
  // R3
  presc_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/mtimer_count.sv
module mtimer_count #(
  parameter int W  = 64,
  parameter int SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [W/2-1:0] wdata_i,
  input  logic          tick_i,
  input  logic [SW-1:0] step_i,
  output logic [W-1:0]  val_o
);
  localparam int HW = W / 2;
  logic [W-1:0] val_q, val_d;

  always_comb begin
    val_d = val_q;
    if (wr_lo_i)      val_d[HW-1:0] = wdata_i;
    else if (wr_hi_i) val_d[W-1:HW] = wdata_i;
    else if (tick_i)  val_d = val_q + W'(step_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else         val_q <= val_d;
  end

  assign val_o = val_q;

  // R1
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_lo_i && !wr_hi_i) |=> $stable(val_q));
  // R3
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_lo_i && !wr_hi_i) |=> (val_q == $past(val_q) + W'($past(step_i))));
  // R4
  cnt_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> (val_q[W-1:HW] == $past(val_q[W-1:HW])));
endmodule

// File: rtl/mtimer_top.sv
module mtimer_top
  import mtimer_pkg::*;
#(
  parameter int PW = 12,
  parameter int SW = 8,
  parameter int CW = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              alert_o
);
  localparam int HW = CW / 2;

  logic          en_q, en_d, ie_q, ie_d, force_q, force_d, alert_q, alert_d;
  logic [PW-1:0] presc_q, presc_d;
  logic [SW-1:0] step_q, step_d;
  logic [CW-1:0] cmp_q, cmp_d, val;
  logic          tick;
  logic wr_alert, wr_ctrl, wr_ie, wr_test, wr_cfg, wr_vlo, wr_vhi, wr_clo, wr_chi;

  assign wr_alert = wr_en_i && (addr_i == OFS_ALERT);
  assign wr_ctrl  = wr_en_i && (addr_i == OFS_CTRL);
  assign wr_ie    = wr_en_i && (addr_i == OFS_IE);
  assign wr_test  = wr_en_i && (addr_i == OFS_TEST);
  assign wr_cfg   = wr_en_i && (addr_i == OFS_CFG);
  assign wr_vlo   = wr_en_i && (addr_i == OFS_VLO);
  assign wr_vhi   = wr_en_i && (addr_i == OFS_VHI);
  assign wr_clo   = wr_en_i && (addr_i == OFS_CLO);
  assign wr_chi   = wr_en_i && (addr_i == OFS_CHI);

  mtimer_prescale #(.PW(PW)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(en_q), .restart_i(wr_cfg),
    .limit_i(presc_q), .tick_o(tick)
  );

  mtimer_count #(.W(CW), .SW(SW)) u_count (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_lo_i(wr_vlo), .wr_hi_i(wr_vhi),
    .wdata_i(wdata_i[HW-1:0]), .tick_i(tick), .step_i(step_q), .val_o(val)
  );

  always_comb begin
    en_d    = wr_ctrl ? wdata_i[0] : en_q;
    ie_d    = wr_ie   ? wdata_i[0] : ie_q;
    presc_d = wr_cfg  ? wdata_i[PW-1:0] : presc_q;
    step_d  = wr_cfg  ? wdata_i[STEP_LSB +: SW] : step_q;
    cmp_d   = cmp_q;
    if (wr_clo) cmp_d[HW-1:0]  = wdata_i[HW-1:0];
    if (wr_chi) cmp_d[CW-1:HW] = wdata_i[HW-1:0];
    force_d = force_q;
    if (wr_test && wdata_i[0]) force_d = 1'b1;
    else if (wr_ctrl || wr_ie || wr_vlo || wr_vhi || wr_clo || wr_chi) force_d = 1'b0;
    alert_d = wr_alert && wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      ie_q    <= 1'b0;
      force_q <= 1'b0;
      alert_q <= 1'b0;
      presc_q <= '0;
      step_q  <= SW'(1);
      cmp_q   <= '1;
    end else begin
      en_q    <= en_d;
      ie_q    <= ie_d;
      force_q <= force_d;
      alert_q <= alert_d;
      presc_q <= presc_d;
      step_q  <= step_d;
      cmp_q   <= cmp_d;
    end
  end

  assign irq_o   = force_q || (en_q && ie_q && (val >= cmp_q));
  assign alert_o = alert_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL: rdata_o[0] = en_q;
      OFS_IE:   rdata_o[0] = ie_q;
      OFS_STAT: rdata_o[0] = irq_o;
      OFS_CFG: begin
        rdata_o[PW-1:0]         = presc_q;
        rdata_o[STEP_LSB +: SW] = step_q;
      end
      OFS_VLO:  rdata_o = val[HW-1:0];
      OFS_VHI:  rdata_o = val[CW-1:HW];
      OFS_CLO:  rdata_o = cmp_q[HW-1:0];
      OFS_CHI:  rdata_o = cmp_q[CW-1:HW];
      default:  rdata_o = '0;
    endcase
  end

  // R9
  alert_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |-> $past(wr_en_i && (addr_i == OFS_ALERT) && wdata_i[0]));
  // R8
  force_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == OFS_TEST) && wdata_i[0]) |=> irq_o);
  // R6
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !force_q) |-> (en_q && ie_q));
  // R5
  cmp_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && ((addr_i == OFS_CLO) || (addr_i == OFS_CHI))) |=> $stable(cmp_q));
endmodule

// File: tb/mtimer_top_test.sv
module mtimer_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, alert;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mtimer_top uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .alert_o(alert)
  );

  // behavioural reference state
  bit m_en, m_ie, m_force, m_alert;
  int unsigned m_presc, m_step, m_div;
  longint unsigned m_val, m_cmp;

  function automatic bit m_irq();
    return m_force || (m_en && m_ie && (m_val >= m_cmp));
  endfunction

  function automatic logic [31:0] m_read(input logic [8:0] a);
    case (a)
      9'h004: return {31'b0, m_en};
      9'h100: return {31'b0, m_ie};
      9'h104: return {31'b0, m_irq()};
      9'h10C: return (m_step << 16) | m_presc;
      9'h110: return m_val[31:0];
      9'h114: return m_val[63:32];
      9'h118: return m_cmp[31:0];
      9'h11C: return m_cmp[63:32];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [8:0] a);
    case (a)
      9'h004: return "R1 ctrl";
      9'h100: return "R12 ie";
      9'h104: return "R7 status";
      9'h10C: return "R2 cfg";
      9'h110, 9'h114: return "R4 value";
      9'h118, 9'h11C: return "R5 compare";
      default: return "R11 zero-read";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_ie = 0; m_force = 0; m_alert = 0;
      m_presc = 0; m_step = 1; m_div = 0;
      m_val = 0; m_cmp = 64'hFFFF_FFFF_FFFF_FFFF;
    end else begin
      bit cfgw, tk;
      cfgw = wr_en && addr == 9'h10C;
      tk = m_en && !cfgw && (m_div == m_presc);
      if (!m_en || cfgw || tk) m_div = 0; else m_div = m_div + 1;
      if (wr_en && addr == 9'h110) m_val = {m_val[63:32], wdata};
      else if (wr_en && addr == 9'h114) m_val = {wdata, m_val[31:0]};
      else if (tk) m_val = m_val + m_step;
      m_alert = wr_en && addr == 9'h000 && wdata[0];
      if (wr_en && addr == 9'h108 && wdata[0]) m_force = 1;
      else if (wr_en && (addr == 9'h004 || addr == 9'h100 || addr == 9'h110 ||
               addr == 9'h114 || addr == 9'h118 || addr == 9'h11C)) m_force = 0;
      if (wr_en) begin
        case (addr)
          9'h004: m_en = wdata[0];
          9'h100: m_ie = wdata[0];
          9'h10C: begin m_presc = wdata[11:0]; m_step = wdata[23:16]; end
          9'h118: m_cmp = {m_cmp[63:32], wdata};
          9'h11C: m_cmp = {wdata, m_cmp[31:0]};
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 irq", irq, m_irq());
      chk("R9 alert", alert, m_alert);
      chk(tag_of(addr), rdata, m_read(addr));
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic watch(input logic [8:0] a, input int n);
    @(posedge clk); #2;
    wr_en = 1'b0; addr = a;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R10 irq in reset", irq, 1'b0);
    chk("R10 alert in reset", alert, 1'b0);
    rst_n = 1'b1;
    // R10 R2 R5 R11 reset readback
    foreach (uut.rdata_o[i]) ; // no-op keeps loop form trivial
    for (int k = 0; k < 12; k++) begin
      logic [8:0] a;
      a = (k < 2) ? 9'(k * 4) : (k < 10) ? 9'(9'h100 + (k - 2) * 4) : (k == 10 ? 9'h008 : 9'h112);
      watch(a, 2);
    end
    // R1 disabled counter holds; R6 gating
    wr(9'h118, 32'd20); wr(9'h11C, 32'd0);
    wr(9'h100, 32'h1);
    watch(9'h110, 10);
    wr(9'h004, 32'hFFFF_FFFF);
    watch(9'h110, 30);
    watch(9'h104, 4);
    // R3 divided tick, restart on cfg write
    wr(9'h10C, 32'hFF05_0003);
    watch(9'h110, 9);
    wr(9'h10C, 32'h0005_0003);
    watch(9'h10C, 2);
    watch(9'h110, 20);
    // R4 carry across halves, write beats tick, R5 high compare
    wr(9'h10C, 32'h0010_0000);
    wr(9'h11C, 32'd1); wr(9'h118, 32'd8);
    wr(9'h110, 32'hFFFF_FFE0);
    watch(9'h114, 6);
    watch(9'h104, 4);
    wr(9'h114, 32'd0);
    watch(9'h110, 3);
    // R7 status write ignored, R11 unmapped write ignored
    wr(9'h104, 32'h0); wr(9'h008, 32'hFFFF_FFFF); wr(9'h10E, 32'hFFFF_FFFF);
    watch(9'h004, 2); watch(9'h11C, 2);
    // R1 disable freezes counter
    wr(9'h004, 32'h0);
    watch(9'h110, 8);
    // R8 forced interrupt while disabled, cleared by ie write
    wr(9'h108, 32'h0);
    watch(9'h104, 3);
    wr(9'h108, 32'h1);
    watch(9'h108, 4);
    chk("R8 forced irq", irq, 1'b1);
    wr(9'h100, 32'h1);
    watch(9'h104, 3);
    chk("R8 force cleared", irq, 1'b0);
    // R9 alert pulses
    wr(9'h000, 32'h0);
    watch(9'h000, 3);
    wr(9'h000, 32'h1);
    chk("R9 alert pulse", alert, 1'b1);
    watch(9'h000, 2);
    chk("R9 alert ends", alert, 1'b0);
    wr(9'h000, 32'h1); wr(9'h000, 32'h1);
    watch(9'h000, 3);
    // R12 ie clear gates interrupt
    wr(9'h004, 32'h1); wr(9'h11C, 32'h0); wr(9'h118, 32'h0);
    watch(9'h104, 3);
    wr(9'h100, 32'h0);
    watch(9'h100, 3);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule